// File: doc/BRIEF.md
# Link Change Interrupt Unit

This block watches the link, duplex and speed inputs of seven switch ports and gives software a register view of them. Each port has a read-only packed status word. Whenever a port's link bit changes, from down to up or from up to down, the block latches a per-port change event in an interrupt status register.

Software clears change events by writing ones to the status register; it normally writes back the value it has just read. A mask register gates which events reach the single level-sensitive interrupt line. A mask bit of 1 blocks that port, and the mask comes out of reset with every port blocked. How the link values are produced (PHY polling or forced settings) is outside this block.

Top module: `link_irq_unit`

## Requirements
- R1: After reset the status register reads 0, the mask register reads 0x7f, every port word reads 0 and `irq_o` is low.
- R2: Port n's word is read at address n (0 to 6). Bit 0 is link up, bit 1 is full duplex, and bits 3:2 are the speed code: 0 = 10, 1 = 100, 2 = 1000 Mb/s, and 3 is passed through unchanged. Bits 31:4 read 0. The word shows the inputs sampled at the previous clock edge.
- R3: Status bit n (bit n of address 8) is set at the first clock edge after port n's link input differs from its value at the edge before. Both rising and falling link changes set the bit.
- R4: A change of duplex or speed while the link is unchanged sets no status bit.
- R5: A write to address 8 clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. Write-data bits 31:7 have no effect.
- R6: If a link change and a clearing write hit the same status bit on the same clock edge, the bit ends up set. Other bits cleared by the same write still clear.
- R7: Address 9 is the mask register. Writing sets it to write-data bits 6:0, and it reads back the same value. A mask bit of 1 blocks port n from the interrupt, so writing 0xffffff80 unblocks all seven ports.
- R8: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. Status bits still latch while they are masked.
- R9: Address 7 and addresses 10 to 15 read 0. Writes to port-word addresses or to unused addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_i | input | 7 | Per-port link up |
| duplex_i | input | 7 | Per-port full duplex |
| speed_i | input | 14 | Per-port 2-bit speed code, port n at bits 2n+1:2n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench drives a link change on the same edge as a clearing write to the same bit. A design that gives the clear priority would silently lose that event. It also changes only duplex and speed, which catches a detector that compares the whole status word rather than the link bit alone. Writes with bits above the port range, and writes to the port-word and unused addresses, expose decoding that is too wide. Masking a pending event and then unmasking it shows whether the status bits keep latching while masked and whether the interrupt line follows the mask.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int SPEED_W = 2;

  typedef struct packed {
    logic [SPEED_W-1:0] speed;
    logic               duplex;
    logic               link;
  } port_word_t;

  localparam int WORD_W = $bits(port_word_t);
endpackage

// File: rtl/link_irq_port.sv
module link_irq_port
  import link_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               link_i,
  input  logic               duplex_i,
  input  logic [SPEED_W-1:0] speed_i,
  output port_word_t         word_o,
  output logic               change_o
);
  port_word_t word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= '{speed: speed_i, duplex: duplex_i, link: link_i};
  end

  // only the link bit raises an event
  assign change_o = link_i ^ word_q.link;
  assign word_o   = word_q;
endmodule

// File: rtl/link_irq_events.sv
module link_irq_events #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] change_i,
  input  logic                 clr_we_i,
  input  logic                 mask_we_i,
  input  logic [NUM_PORTS-1:0] wdata_i,
  output logic [NUM_PORTS-1:0] status_o,
  output logic [NUM_PORTS-1:0] mask_o,
  output logic                 irq_o
);
  logic [NUM_PORTS-1:0] status_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_bits) | change_i; // set beats clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);
endmodule

// File: rtl/link_irq_regs.sv
module link_irq_regs
  import link_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_STATUS = 8,
  parameter int ADDR_MASK   = 9
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  port_word_t           words_i [NUM_PORTS],
  input  logic [NUM_PORTS-1:0] status_i,
  input  logic [NUM_PORTS-1:0] mask_i,
  output logic [DATA_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_STATUS)) begin
      rdata_o[NUM_PORTS-1:0] = status_i;
    end else if (addr_i == ADDR_W'(ADDR_MASK)) begin
      rdata_o[NUM_PORTS-1:0] = mask_i;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (addr_i == ADDR_W'(i)) rdata_o[WORD_W-1:0] = words_i[i];
      end
    end
  end
endmodule

// File: rtl/link_irq_unit.sv
module link_irq_unit
  import link_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_STATUS = 8,
  parameter int ADDR_MASK   = 9
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PORTS-1:0]         link_i,
  input  logic [NUM_PORTS-1:0]         duplex_i,
  input  logic [NUM_PORTS*SPEED_W-1:0] speed_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic                         irq_o
);
  port_word_t           port_words [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_change;
  logic [NUM_PORTS-1:0] ev_status, ev_mask;
  logic                 clr_we, mask_we;
  logic                 unused_wdata;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    link_irq_port u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .link_i   (link_i[p]),
      .duplex_i (duplex_i[p]),
      .speed_i  (speed_i[p*SPEED_W +: SPEED_W]),
      .word_o   (port_words[p]),
      .change_o (port_change[p])
    );
  end

  assign clr_we       = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
  assign mask_we      = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_MASK));
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:NUM_PORTS];

  link_irq_events #(.NUM_PORTS(NUM_PORTS)) u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .change_i  (port_change),
    .clr_we_i  (clr_we),
    .mask_we_i (mask_we),
    .wdata_i   (reg_wdata_i[NUM_PORTS-1:0]),
    .status_o  (ev_status),
    .mask_o    (ev_mask),
    .irq_o     (irq_o)
  );

  link_irq_regs #(
    .NUM_PORTS   (NUM_PORTS),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ADDR_STATUS (ADDR_STATUS),
    .ADDR_MASK   (ADDR_MASK)
  ) u_regs (
    .addr_i   (reg_addr_i),
    .words_i  (port_words),
    .status_i (ev_status),
    .mask_i   (ev_mask),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/link_irq_unit_chk.sv
module link_irq_unit_chk #(
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_W      = 4,
  parameter int ADDR_STATUS = 8,
  parameter int ADDR_MASK   = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PORTS-1:0] link_i,
  input logic                 reg_we_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [NUM_PORTS-1:0] wdata_i,
  input logic [NUM_PORTS-1:0] status_i,
  input logic [NUM_PORTS-1:0] mask_i,
  input logic                 irq_o
);
  logic                 started_q;
  logic [NUM_PORTS-1:0] prev_q;
  logic                 st_wr, mk_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      prev_q    <= '0;
    end else begin
      started_q <= 1'b1;
      prev_q    <= link_i;
    end
  end

  assign st_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
  assign mk_wr = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_MASK));

  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> (status_i == '0 && mask_i == '1 && !irq_o));

  a_r3_r6_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && link_i != prev_q) |=>
      ((status_i & $past(link_i ^ prev_q)) == $past(link_i ^ prev_q)));

  a_r4_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && link_i == prev_q) |=> ((status_i & ~$past(status_i)) == '0));

  a_r5_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && st_wr) |=>
      ((status_i & $past(wdata_i & ~(link_i ^ prev_q))) == '0));

  a_r9_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_wr |=> $stable(mask_i));

  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & ~mask_i) == '0) |-> !irq_o);

  a_r8_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & ~mask_i) != '0) |-> irq_o);
endmodule

bind link_irq_unit link_irq_unit_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .ADDR_W      (ADDR_W),
  .ADDR_STATUS (ADDR_STATUS),
  .ADDR_MASK   (ADDR_MASK)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .link_i     (link_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .wdata_i    (reg_wdata_i[NUM_PORTS-1:0]),
  .status_i   (ev_status),
  .mask_i     (ev_mask),
  .irq_o      (irq_o)
);

// File: tb/link_irq_unit_test.sv
`timescale 1ns/1ps
module link_irq_unit_test;
  localparam int NP = 7;
  localparam int A_STAT = 8;
  localparam int A_MASK = 9;
  // vector: {speed[13:0], duplex[6:0], link[6:0]}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {14'h0002, 7'h01, 7'h01},
    {14'h1a5b, 7'h55, 7'h7f},
    {14'h3fff, 7'h7f, 7'h7f},
    {14'h0000, 7'h00, 7'h2a},
    {14'h2492, 7'h49, 7'h55},
    {14'h0000, 7'h00, 7'h00}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [6:0]  link, duplex;
  logic [13:0] speed;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic [31:0] rd;
  logic [6:0]  prev;

  always #5 clk = ~clk;

  link_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .link_i(link), .duplex_i(duplex),
    .speed_i(speed), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = 4'(a); wdata = d;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rdr(input int a, output logic [31:0] d);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] exp_word(input logic [27:0] v, input int p);
    return {28'd0, v[14+2*p +: 2], v[7+p], v[p]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; link = '0; duplex = '0; speed = '0;
    we = 1'b0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    rdr(A_STAT, rd); check("R1 status", rd, 32'h0);
    rdr(A_MASK, rd); check("R1 mask", rd, 32'h7f);
    check("R1 irq", {31'd0, irq}, 32'h0);
    for (int p = 0; p < NP; p++) begin
      rdr(p, rd); check("R1 port word", rd, 32'h0);
    end

    // R7 unmask all with complement of 0x7f
    wr(A_MASK, 32'hffffff80);
    rdr(A_MASK, rd); check("R7 mask readback", rd, 32'h0);

    // vector table
    prev = '0;
    for (int i = 0; i < NV; i++) begin
      wr(A_STAT, 32'h7f);
      {speed, duplex, link} = VEC[i];
      tick();
      rdr(A_STAT, rd); check("R3 change bits", rd, {25'd0, prev ^ VEC[i][6:0]});
      check("R8 irq follows", {31'd0, irq}, {31'd0, |(prev ^ VEC[i][6:0])});
      for (int p = 0; p < NP; p++) begin
        rdr(p, rd); check("R2 port word", rd, exp_word(VEC[i], p));
      end
      prev = VEC[i][6:0];
    end

    // R4 duplex/speed only
    wr(A_STAT, 32'h7f);
    duplex = 7'h7f; speed = 14'h3fff;
    tick();
    rdr(A_STAT, rd); check("R4 no event", rd, 32'h0);
    rdr(0, rd); check("R2 word speed3 dup", rd, 32'he);

    // R5 write-one-to-clear
    link = 7'h7f; tick();
    rdr(A_STAT, rd); check("R3 all up", rd, 32'h7f);
    wr(A_STAT, 32'hffffff80);
    rdr(A_STAT, rd); check("R5 upper bits ignored", rd, 32'h7f);
    wr(A_STAT, 32'h05);
    rdr(A_STAT, rd); check("R5 partial clear", rd, 32'h7a);

    // R6 set wins over clear
    link = 7'h7e;
    wr(A_STAT, 32'h03);
    rdr(A_STAT, rd); check("R6 set beats clear", rd, 32'h79);

    // R7/R8 masking
    wr(A_STAT, 32'h7f);
    check("R8 irq low when clear", {31'd0, irq}, 32'h0);
    link = 7'h76; tick();
    check("R8 irq on event", {31'd0, irq}, 32'h1);
    wr(A_MASK, 32'h08);
    check("R7 masked irq", {31'd0, irq}, 32'h0);
    rdr(A_MASK, rd); check("R7 mask readback", rd, 32'h08);
    wr(A_STAT, 32'h08);
    link = 7'h7e; tick();
    rdr(A_STAT, rd); check("R8 latch while masked", rd, 32'h08);
    check("R8 irq stays low", {31'd0, irq}, 32'h0);
    wr(A_MASK, 32'h0);
    check("R7 unmask raises irq", {31'd0, irq}, 32'h1);

    // R9 decode
    rdr(7, rd);  check("R9 addr7", rd, 32'h0);
    rdr(10, rd); check("R9 addr10", rd, 32'h0);
    rdr(15, rd); check("R9 addr15", rd, 32'h0);
    wr(0, 32'h0000000f);
    rdr(0, rd); check("R9 port word not writable", rd, 32'he);
    wr(7, 32'hffffffff);
    rdr(A_STAT, rd); check("R9 status untouched", rd, 32'h08);
    rdr(A_MASK, rd); check("R9 mask untouched", rd, 32'h0);

    // R1 again after reset mid-run
    rst_ni = 1'b0; tick(); rst_ni = 1'b1;
    link = '0; duplex = '0; speed = '0;
    tick();
    rdr(A_MASK, rd); check("R1 mask after reset", rd, 32'h7f);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule